// File: doc/BRIEF.md
# Shared Line Band Source Selector

This block sits beside one video channel of a multi-channel graphics overlay engine. For every display line it decides whether that channel's graphics come from its own memory or from another channel's memory. Software programs a begin line, an end line and a source-channel mask over a byte-wide register bus. Each 9-bit line value is written as a high byte and then a low byte. A value goes live only once its low byte is written, so a half-written line number is never in use.

New settings can go live on the next clock or wait for the next video field boundary. The control register picks which. In field-synchronous mode each committed value waits in a shadow register until the field-start pulse arrives. A second low-byte write before that pulse replaces the waiting value. The source mask has one bit per channel. Only channels of the same parity (even or odd) as the owning channel count, and the lowest-numbered qualifying channel wins. The video timing generator supplies the current line number, a field-start pulse and the video standard.

Top module: `shared_band_sel`

## Requirements
- R1: After reset the begin line, end line and source mask are zero and field-synchronous mode is selected. No line is shared, and `data_ch` equals `OWN_CH`.
- R2: A write to a high-byte register (address 0 for begin, address 2 for end) leaves the line value in use unchanged. Only bit 0 of that byte is stored, and it becomes bit 8 of the value.
- R3: With control bit 0 (address 5) set, a low-byte write (address 1 for begin, address 3 for end) puts {stored high bit, written byte} in use from the next clock.
- R4: With control bit 0 clear, a low-byte write is held pending and goes into use on the clock where `field_start` is high. A later low-byte write before that pulse replaces the pending value.
- R5: The source mask (address 4) follows the same immediate or field-synchronous commit rule as the line values.
- R6: A line shares data when it lies in the range begin through end, inclusive at both ends, and a qualifying source bit exists. Every other line uses the channel's own memory.
- R7: When begin is greater than end, no line shares data.
- R8: With `std_pal` low, lines above 483 never share data. With `std_pal` high, lines up to 511 may share data.
- R9: Mask bits whose channel parity differs from `OWN_CH` are ignored. If no bit of the matching parity is set, no line shares data.
- R10: When several bits of the matching parity are set, the lowest-numbered of those channels is the source.
- R11: `data_ch` gives the source channel index while a line is shared, and `OWN_CH` otherwise. `share_hit` is high exactly while a line is shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..5) |
| wr_data | input | 8 | Register write byte |
| field_start | input | 1 | One-cycle pulse at each video field boundary |
| line_num | input | 9 | Current display line number |
| std_pal | input | 1 | 1 selects the 0..511 line range, 0 selects 0..483 |
| share_hit | output | 1 | Current line takes data from another channel |
| data_ch | output | 3 | Channel index that supplies data for the current line |

## Verification
The bench builds the block with eight channels, 9-bit lines and `OWN_CH` = 3. With an odd owning channel, both the parity filter and the lowest-channel choice among odd bits can be exercised, while even bits act as noise that must be ignored. Directed sequences cover the edges at 483/484 and 511, inverted ranges, high-byte-only writes and replacement of a pending value. Random traffic then mixes writes, field pulses and both standards. This random mix also covers writes that land on the same cycle as a field pulse.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        REG_BEG_HI = 3'd0,
        REG_BEG_LO = 3'd1,
        REG_END_HI = 3'd2,
        REG_END_LO = 3'd3,
        REG_SRC    = 3'd4,
        REG_CTRL   = 3'd5
    } sbs_reg_e;

    localparam int CTRL_ASYNC_BIT = 0;

endpackage

// File: rtl/sbs_commit_slot.sv
module sbs_commit_slot #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         immediate,
    input  logic         field_start,
    output logic [W-1:0] live
);

    typedef struct packed {
        logic [W-1:0] live;
        logic [W-1:0] shadow;
        logic         waiting;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (field_start && st_q.waiting) begin
            st_d.live    = st_q.shadow;
            st_d.waiting = 1'b0;
        end
        if (load) begin
            if (immediate) begin
                st_d.live    = load_val;
                st_d.waiting = 1'b0;
            end else begin
                st_d.shadow  = load_val;
                st_d.waiting = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;

endmodule

// File: rtl/sbs_src_pick.sv
module sbs_src_pick #(
    parameter int NUM_CH = 8,
    parameter int OWN_CH = 3,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask,
    output logic              found,
    output logic [CH_W-1:0]   pick
);

    logic [NUM_CH-1:0] kept;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_par
            if ((g % 2) == (OWN_CH % 2)) begin : g_keep
                assign kept[g] = mask[g];
            end else begin : g_drop
                assign kept[g] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (kept[i]) begin
                found = 1'b1;
                pick  = CH_W'(i);
            end
        end
    end

endmodule

// File: rtl/sbs_band_cmp.sv
module sbs_band_cmp #(
    parameter int LINE_W    = 9,
    parameter int NTSC_LAST = 483,
    parameter int PAL_LAST  = 511
) (
    input  logic [LINE_W-1:0] beg_line,
    input  logic [LINE_W-1:0] end_line,
    input  logic [LINE_W-1:0] line_num,
    input  logic              std_pal,
    output logic              in_band
);

    localparam logic [LINE_W-1:0] NTSC_LIM = LINE_W'(NTSC_LAST);
    localparam logic [LINE_W-1:0] PAL_LIM  = LINE_W'(PAL_LAST);

    logic [LINE_W-1:0] lim;
    logic              legal;

    always_comb begin
        lim     = std_pal ? PAL_LIM : NTSC_LIM;
        legal   = (line_num <= lim);
        in_band = legal && (line_num >= beg_line) && (line_num <= end_line);
    end

endmodule

// File: rtl/shared_band_sel.sv
module shared_band_sel #(
    parameter int NUM_CH    = 8,
    parameter int OWN_CH    = 3,
    parameter int LINE_W    = 9,
    parameter int NTSC_LAST = 483,
    parameter int PAL_LAST  = 511,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int HI_W     = LINE_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              field_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              std_pal,
    output logic              share_hit,
    output logic [CH_W-1:0]   data_ch
);
    import sbs_pkg::*;

    typedef struct packed {
        logic [HI_W-1:0] beg_hi;
        logic [HI_W-1:0] end_hi;
        logic            async_mode;
    } bus_t;

    bus_t bus_d, bus_q;

    logic              ld_beg, ld_end, ld_src;
    logic [LINE_W-1:0] beg_val, end_val;
    logic [LINE_W-1:0] live_line [2];
    logic [LINE_W-1:0] act_beg, act_end;
    logic [NUM_CH-1:0] act_src;
    logic              src_found, in_band;
    logic [CH_W-1:0]   src_idx;
    logic [HI_W-1:0]   beg_hi_w;
    logic              async_w;

    always_comb begin
        bus_d  = bus_q;
        ld_beg = 1'b0;
        ld_end = 1'b0;
        ld_src = 1'b0;
        if (wr_en) begin
            unique case (wr_addr)
                REG_BEG_HI: bus_d.beg_hi     = wr_data[HI_W-1:0];
                REG_BEG_LO: ld_beg           = 1'b1;
                REG_END_HI: bus_d.end_hi     = wr_data[HI_W-1:0];
                REG_END_LO: ld_end           = 1'b1;
                REG_SRC:    ld_src           = 1'b1;
                REG_CTRL:   bus_d.async_mode = wr_data[CTRL_ASYNC_BIT];
                default: ;
            endcase
        end
        beg_val = {bus_q.beg_hi, wr_data};
        end_val = {bus_q.end_hi, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= '0;
        end else begin
            bus_q <= bus_d;
        end
    end

    generate
        for (genvar k = 0; k < 2; k++) begin : g_line_slot
            sbs_commit_slot #(.W(LINE_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       ((k == 0) ? ld_beg : ld_end),
                .load_val   ((k == 0) ? beg_val : end_val),
                .immediate  (bus_q.async_mode),
                .field_start(field_start),
                .live       (live_line[k])
            );
        end
    endgenerate

    sbs_commit_slot #(.W(NUM_CH)) u_src_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld_src),
        .load_val   (wr_data[NUM_CH-1:0]),
        .immediate  (bus_q.async_mode),
        .field_start(field_start),
        .live       (act_src)
    );

    assign act_beg  = live_line[0];
    assign act_end  = live_line[1];
    assign beg_hi_w = bus_q.beg_hi;
    assign async_w  = bus_q.async_mode;

    sbs_src_pick #(.NUM_CH(NUM_CH), .OWN_CH(OWN_CH)) u_pick (
        .mask (act_src),
        .found(src_found),
        .pick (src_idx)
    );

    sbs_band_cmp #(.LINE_W(LINE_W), .NTSC_LAST(NTSC_LAST), .PAL_LAST(PAL_LAST)) u_cmp (
        .beg_line(act_beg),
        .end_line(act_end),
        .line_num(line_num),
        .std_pal (std_pal),
        .in_band (in_band)
    );

    always_comb begin
        share_hit = src_found && in_band;
        data_ch   = share_hit ? src_idx : CH_W'(OWN_CH);
    end

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int NUM_CH    = 8,
    parameter int OWN_CH    = 3,
    parameter int LINE_W    = 9,
    parameter int NTSC_LAST = 483,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int HI_W     = LINE_W - 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [7:0]        wr_data,
    input logic              field_start,
    input logic [LINE_W-1:0] line_num,
    input logic              std_pal,
    input logic              share_hit,
    input logic [CH_W-1:0]   data_ch,
    input logic [LINE_W-1:0] act_beg,
    input logic [LINE_W-1:0] act_end,
    input logic [HI_W-1:0]   beg_hi_w,
    input logic              async_w
);

    localparam logic [LINE_W-1:0] NTSC_LIM = LINE_W'(NTSC_LAST);

    // R2
    hi_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0 && !field_start) |=> $stable(act_beg));

    // R3
    async_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1 && async_w) |=>
        (act_beg == {$past(beg_hi_w), $past(wr_data)}));

    // R4
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd1 && !async_w && !field_start) |=> $stable(act_beg));

    // R7
    inverted_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_beg > act_end) |-> !share_hit);

    // R8
    ntsc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!std_pal && line_num > NTSC_LIM) |-> !share_hit);

    // R9
    parity_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        share_hit |-> (data_ch[0] == 1'(OWN_CH % 2)));

    // R11
    own_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !share_hit |-> (data_ch == CH_W'(OWN_CH)));

endmodule

bind shared_band_sel sbs_chk #(
    .NUM_CH(NUM_CH), .OWN_CH(OWN_CH), .LINE_W(LINE_W), .NTSC_LAST(NTSC_LAST)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .field_start(field_start),
    .line_num   (line_num),
    .std_pal    (std_pal),
    .share_hit  (share_hit),
    .data_ch    (data_ch),
    .act_beg    (act_beg),
    .act_end    (act_end),
    .beg_hi_w   (beg_hi_w),
    .async_w    (async_w)
);

// File: tb/shared_band_sel_tb.sv
`timescale 1ns/1ps
module shared_band_sel_tb;

    localparam int OWN = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       field_start = 1'b0;
    logic [8:0] line_num = '0;
    logic       std_pal = 1'b0;
    logic       share_hit;
    logic [2:0] data_ch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic       m_bhi, m_ehi, m_async;
    logic [8:0] m_live [3];
    logic [8:0] m_shad [3];
    logic       m_wait [3];

    always #10 clk = ~clk;

    shared_band_sel #(.NUM_CH(8), .OWN_CH(OWN), .LINE_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .field_start(field_start), .line_num(line_num),
        .std_pal(std_pal), .share_hit(share_hit), .data_ch(data_ch)
    );

    function automatic void model_reset();
        m_bhi = 0; m_ehi = 0; m_async = 0;
        for (int i = 0; i < 3; i++) begin
            m_live[i] = '0; m_shad[i] = '0; m_wait[i] = 0;
        end
    endfunction

    function automatic void exp_out(input logic [8:0] ln, input logic pal,
                                    output logic hit, output logic [2:0] ch);
        logic       found = 0;
        logic [2:0] src = 0;
        int         lim = pal ? 511 : 483;
        for (int i = 7; i >= 0; i--)
            if (m_live[2][i] && (i % 2) == (OWN % 2)) begin
                found = 1; src = 3'(i);
            end
        hit = found && (int'(ln) <= lim) && (ln >= m_live[0]) && (ln <= m_live[1]);
        ch  = hit ? src : 3'(OWN);
    endfunction

    function automatic void model_edge(input logic en, input logic [2:0] a,
                                       input logic [7:0] d, input logic fs);
        int         slot = -1;
        logic [8:0] v = '0;
        for (int i = 0; i < 3; i++)
            if (fs && m_wait[i]) begin
                m_live[i] = m_shad[i]; m_wait[i] = 0;
            end
        if (en) begin
            case (a)
                3'd0: m_bhi = d[0];
                3'd1: begin slot = 0; v = {m_bhi, d}; end
                3'd2: m_ehi = d[0];
                3'd3: begin slot = 1; v = {m_ehi, d}; end
                3'd4: begin slot = 2; v = {1'b0, d}; end
                3'd5: m_async = d[0];
                default: ;
            endcase
        end
        if (slot >= 0) begin
            if (m_async) begin
                m_live[slot] = v; m_wait[slot] = 0;
            end else begin
                m_shad[slot] = v; m_wait[slot] = 1;
            end
        end
    endfunction

    task automatic step(input logic en, input logic [2:0] a, input logic [7:0] d,
                        input logic fs, input logic [8:0] ln, input logic pal,
                        input string tag);
        logic       eh;
        logic [2:0] ec;
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d; field_start = fs;
        line_num = ln; std_pal = pal;
        #1;
        exp_out(ln, pal, eh, ec);
        n_chk++;
        if (share_hit !== eh || data_ch !== ec) begin
            n_bad++;
            $display("FAIL %s line=%0d pal=%0d: hit=%0b ch=%0d expected hit=%0b ch=%0d",
                     tag, ln, pal, share_hit, data_ch, eh, ec);
        end
        model_edge(en, a, d, fs);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 9'd0, 1'b0, tag);
    endtask

    task automatic look(input logic [8:0] ln, input logic pal, input string tag);
        step(1'b0, 3'd0, 8'd0, 1'b0, ln, pal, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        look(9'd0, 1'b0, "R1");
        look(9'd100, 1'b1, "R1");

        // R3 immediate commit, R10 lowest odd wins among 5 and 7
        wr(3'd5, 8'h01, "R3");
        wr(3'd4, 8'b1010_0100, "R10");
        wr(3'd0, 8'h01, "R3");
        wr(3'd1, 8'h10, "R3");     // begin 272
        wr(3'd2, 8'h01, "R3");
        wr(3'd3, 8'hE3, "R3");     // end 483
        look(9'd271, 1'b0, "R6");
        look(9'd272, 1'b0, "R6");
        look(9'd483, 1'b0, "R6");
        look(9'd484, 1'b0, "R8");
        look(9'd484, 1'b1, "R8");
        wr(3'd3, 8'hFF, "R3");     // end 511
        look(9'd511, 1'b1, "R8");
        look(9'd500, 1'b0, "R8");

        // R2 high byte alone keeps begin at 272
        wr(3'd0, 8'h00, "R2");
        look(9'd271, 1'b0, "R2");
        wr(3'd1, 8'h10, "R2");     // begin 16
        look(9'd16, 1'b0, "R2");

        // R9 even-only mask ignored, then mixed mask picks channel 1
        wr(3'd4, 8'b0000_0101, "R9");
        look(9'd100, 1'b0, "R9");
        wr(3'd4, 8'b0000_0110, "R9");
        look(9'd100, 1'b0, "R11");

        // R4 field-synchronous commit with replacement
        wr(3'd5, 8'h00, "R4");
        wr(3'd1, 8'hC8, "R4");
        look(9'd100, 1'b0, "R4");
        wr(3'd1, 8'h96, "R4");
        step(1'b0, 3'd0, 8'd0, 1'b1, 9'd100, 1'b0, "R4");
        look(9'd149, 1'b0, "R4");
        look(9'd150, 1'b0, "R4");
        look(9'd199, 1'b0, "R4");

        // R5 source mask waits for field start
        wr(3'd4, 8'h80, "R5");
        look(9'd160, 1'b0, "R5");
        step(1'b0, 3'd0, 8'd0, 1'b1, 9'd160, 1'b0, "R5");
        look(9'd160, 1'b0, "R5");

        // R7 inverted range
        wr(3'd5, 8'h01, "R7");
        wr(3'd0, 8'h01, "R7");
        wr(3'd1, 8'h2C, "R7");     // begin 300
        wr(3'd2, 8'h00, "R7");
        wr(3'd3, 8'h64, "R7");     // end 100
        look(9'd100, 1'b0, "R7");
        look(9'd200, 1'b1, "R7");
        look(9'd300, 1'b1, "R7");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic       en = ($urandom_range(0, 2) == 0);
            logic [2:0] a  = 3'($urandom_range(0, 5));
            logic [7:0] d  = 8'($urandom);
            logic       fs = ($urandom_range(0, 7) == 0);
            logic [8:0] ln = 9'($urandom);
            logic       pal = 1'($urandom);
            step(en, a, d, fs, ln, pal, "R6");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule